// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a small set of three 16-bit registers on a simple synchronous bus. Every cycle presents one byte address, a size bit (byte or word) and an optional write. A control register holds a one-byte setting in its low half, and its high half acts as a key slot. Writing the correct key opens the bank for writes to the protected registers. A byte write of any other key to that slot closes the bank again without further effect.

Some writes break the rules: a word write to the control register with a bad key, or a write to the flag register while the bank is closed. Each one produces a single-cycle reset request. The request also returns the bank to its reset values and to the closed state. A separate power-mode register stays writable at all times. Reads are registered, so data appears one clock after the address is presented, and they have no side effects.

Top module: `keyed_regbank`

## Requirements
- R1: After reset the control register reads 9660h, the flag register (offset 0Ah) and the power-mode register (offset 10h) read 0000h, rst_req is 0 and the bank is closed.
- R2: Each register is a 16-bit word at its even offset (word access, word=1). A byte access (word=0) at the even offset reaches bits 7:0, and one at offset+1 reaches bits 15:8. A byte write takes its data from wdata[7:0] and changes only the addressed byte. A byte read returns the byte in rdata[7:0] with rdata[15:8]=0.
- R3: The control register's high byte always reads 96h, whatever was written to it.
- R4: A byte write of A5h to offset 01h opens the bank. Afterwards, writes to the flag register and byte writes to the control low byte take effect and raise no reset request.
- R5: A byte write of any value other than A5h to offset 01h closes the bank and raises no reset request.
- R6: A word write to offset 00h whose wdata[15:8] is A5h opens the bank and loads wdata[7:0] into the control low byte in the same cycle.
- R7: A word write to offset 00h whose wdata[15:8] is not A5h raises a reset request.
- R8: Any write to the flag register while the bank is closed raises a reset request and does not change the register.
- R9: The power-mode register is written whether the bank is open or closed, and writing it never raises a reset request.
- R10: rst_req goes high for exactly one cycle, starting at the clock edge that takes the violating write. At the following edge all registers return to their reset values and the bank closes.
- R11: A read of an unmapped offset, or a word access at an odd offset, returns 0000h. Writes there change nothing and raise no reset request.
- R12: A byte write to the control low byte while the bank is closed is ignored and raises no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the access |
| word | input | 1 | 1 = 16-bit access, 0 = byte access |
| wr_en | input | 1 | Write strobe for this cycle |
| wdata | input | 16 | Write data (byte writes use bits 7:0) |
| rdata | output | 16 | Registered read data for the previous cycle's address |
| rst_req | output | 1 | Single-cycle reset request on a rule violation |

## Verification
The assertions assume that addr, word, wr_en and wdata are stable around each rising edge and defined whenever reset is low. They also assume that nothing written in the cycle when rst_req is high is expected to land, because the reset it requests takes priority. The stimulus changes inputs one time unit after an edge and puts an idle cycle after every expected violation, so the block's own reset completes before the next access. Every read is sampled one cycle after its address is presented.

// File: rtl/keyed_regbank_pkg.sv
package keyed_regbank_pkg;
  localparam int DW = 16;
  localparam int BW = 8;
  localparam logic [BW-1:0] UNLOCK_KEY = 8'hA5;
  localparam logic [BW-1:0] CTL_HI_RD  = 8'h96;
  localparam logic [BW-1:0] CTL_LO_RST = 8'h60;
  localparam int OFS_CTL = 'h00;
  localparam int OFS_IFG = 'h0A;
  localparam int OFS_PM5 = 'h10;

  typedef struct packed {
    logic ctl_lo;
    logic ctl_hi;
    logic ifg_lo;
    logic ifg_hi;
    logic pm5_lo;
    logic pm5_hi;
  } lanes_t;
endpackage

// File: rtl/keyed_regbank_decode.sv
module keyed_regbank_decode
  import keyed_regbank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              word,
  output lanes_t            hit
);
  function automatic logic [1:0] lane_hit(input logic [ADDR_W-1:0] a,
                                          input logic w, input int base);
    logic [1:0] r;
    r = 2'b00;
    if (w) begin
      if (int'(a) == base) r = 2'b11;
    end else begin
      if (int'(a) == base)     r = 2'b01;
      if (int'(a) == base + 1) r = 2'b10;
    end
    return r;
  endfunction

  logic [1:0] h_ctl, h_ifg, h_pm5;

  always_comb begin
    h_ctl = lane_hit(addr, word, OFS_CTL);
    h_ifg = lane_hit(addr, word, OFS_IFG);
    h_pm5 = lane_hit(addr, word, OFS_PM5);
    hit.ctl_lo = h_ctl[0];
    hit.ctl_hi = h_ctl[1];
    hit.ifg_lo = h_ifg[0];
    hit.ifg_hi = h_ifg[1];
    hit.pm5_lo = h_pm5[0];
    hit.pm5_hi = h_pm5[1];
  end
endmodule

// File: rtl/keyed_regbank_guard.sv
module keyed_regbank_guard
  import keyed_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          word,
  input  lanes_t        hit,
  input  logic [DW-1:0] wdata,
  output logic          unlocked,
  output logic          rst_req,
  output lanes_t        commit
);
  logic key_ok, ctl_word, ifg_any, viol, live, active;

  always_comb begin
    key_ok   = word ? (wdata[DW-1:BW] == UNLOCK_KEY) : (wdata[BW-1:0] == UNLOCK_KEY);
    active   = wr_en && !rst_req;
    ctl_word = hit.ctl_hi && word;
    ifg_any  = hit.ifg_lo || hit.ifg_hi;
    viol     = active && ((ctl_word && !key_ok) || (ifg_any && !unlocked));
    live     = active && !viol;
    commit.ctl_lo = live && hit.ctl_lo && (unlocked || (word && key_ok));
    commit.ctl_hi = 1'b0;
    commit.ifg_lo = live && hit.ifg_lo && unlocked;
    commit.ifg_hi = live && hit.ifg_hi && unlocked;
    commit.pm5_lo = live && hit.pm5_lo;
    commit.pm5_hi = live && hit.pm5_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) rst_req <= 1'b0;
    else     rst_req <= viol;
  end

  always_ff @(posedge clk) begin
    if (rst || rst_req)            unlocked <= 1'b0;
    else if (active && hit.ctl_hi) unlocked <= key_ok && !viol;
  end
endmodule

// File: rtl/keyed_regbank_lanereg.sv
module keyed_regbank_lanereg
  import keyed_regbank_pkg::*;
#(
  parameter int            NLANE   = DW / BW,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [NLANE-1:0] we,
  input  logic             word,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    q
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (clr)        q[g*BW +: BW] <= RST_VAL[g*BW +: BW];
      else if (we[g]) q[g*BW +: BW] <= word ? wdata[g*BW +: BW] : wdata[BW-1:0];
    end
  end
endmodule

// File: rtl/keyed_regbank.sv
module keyed_regbank
  import keyed_regbank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              word,
  input  logic              wr_en,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rst_req
);
  lanes_t        hit, commit;
  logic          unlocked, clr;
  logic [BW-1:0] ctl_lo;
  logic [DW-1:0] ifg_q, pm5_q, rd_word, rd_next;

  keyed_regbank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .word(word), .hit(hit)
  );

  keyed_regbank_guard u_guard (
    .clk(clk), .rst(rst), .wr_en(wr_en), .word(word), .hit(hit),
    .wdata(wdata), .unlocked(unlocked), .rst_req(rst_req), .commit(commit)
  );

  assign clr = rst || rst_req;

  always_ff @(posedge clk) begin
    if (clr)              ctl_lo <= CTL_LO_RST;
    else if (commit.ctl_lo) ctl_lo <= wdata[BW-1:0];
  end

  keyed_regbank_lanereg #(.RST_VAL(16'h0000)) u_ifg (
    .clk(clk), .clr(clr), .we({commit.ifg_hi, commit.ifg_lo}),
    .word(word), .wdata(wdata), .q(ifg_q)
  );

  keyed_regbank_lanereg #(.RST_VAL(16'h0000)) u_pm5 (
    .clk(clk), .clr(clr), .we({commit.pm5_hi, commit.pm5_lo}),
    .word(word), .wdata(wdata), .q(pm5_q)
  );

  always_comb begin
    rd_word = '0;
    if (hit.ctl_lo || hit.ctl_hi) rd_word = {CTL_HI_RD, ctl_lo};
    if (hit.ifg_lo || hit.ifg_hi) rd_word = ifg_q;
    if (hit.pm5_lo || hit.pm5_hi) rd_word = pm5_q;
    if (word)
      rd_next = rd_word;
    else if (hit.ctl_hi || hit.ifg_hi || hit.pm5_hi)
      rd_next = {{BW{1'b0}}, rd_word[DW-1:BW]};
    else
      rd_next = {{BW{1'b0}}, rd_word[BW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/keyed_regbank_chk.sv
module keyed_regbank_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              word,
  input logic              wr_en,
  input logic [15:0]       wdata,
  input logic [15:0]       rdata,
  input logic              rst_req,
  input logic              unlocked
);
  logic mapped;
  always_comb begin
    if (word) mapped = (addr == 'h00) || (addr == 'h0A) || (addr == 'h10);
    else      mapped = (addr == 'h00) || (addr == 'h01) || (addr == 'h0A) ||
                       (addr == 'h0B) || (addr == 'h10) || (addr == 'h11);
  end

  // R10: request lasts a single cycle and leaves the bank closed
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> (!rst_req && !unlocked));

  // R7
  a_r7_word_bad_key: assert property (@(posedge clk) disable iff (rst)
    (wr_en && word && addr == 'h00 && wdata[15:8] != 8'hA5 && !rst_req) |=> rst_req);

  // R5
  a_r5_byte_relock: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !word && addr == 'h01 && wdata[7:0] != 8'hA5 && !rst_req) |=> (!rst_req && !unlocked));

  // R8
  a_r8_locked_flag_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !unlocked && !rst_req && ((word && addr == 'h0A) || (!word && (addr == 'h0A || addr == 'h0B))))
    |=> rst_req);

  // R9
  a_r9_pm5_no_request: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rst_req && (addr == 'h10 || (!word && addr == 'h11))) |=> !rst_req);

  // R3
  a_r3_ctl_hi_const: assert property (@(posedge clk) disable iff (rst)
    (!word && addr == 'h01) |=> (rdata == 16'h0096));

  // R11
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> (rdata == 16'h0000));

  a_r11_unmapped_no_request: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mapped && !rst_req) |=> !rst_req);
endmodule

bind keyed_regbank keyed_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .word(word), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .rst_req(rst_req), .unlocked(unlocked)
);

// File: tb/keyed_regbank_test.sv
module keyed_regbank_test;
  localparam int ADDR_W = 5;

  typedef struct packed {
    logic        is_wr;
    logic        word;
    logic [4:0]  addr;
    logic [15:0] wdata;
    logic [15:0] exp;   // expected rdata for reads
    logic        req;   // expected rst_req for writes
    logic [3:0]  rq;    // requirement number for messages
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 5'h00, 16'h0000, 16'h9660, 1'b0, 4'd1},  // R1
    '{1'b0, 1'b1, 5'h0A, 16'h0000, 16'h0000, 1'b0, 4'd1},  // R1
    '{1'b0, 1'b1, 5'h10, 16'h0000, 16'h0000, 1'b0, 4'd1},  // R1
    '{1'b1, 1'b1, 5'h10, 16'h1234, 16'h0000, 1'b0, 4'd9},  // R9 locked write
    '{1'b0, 1'b1, 5'h10, 16'h0000, 16'h1234, 1'b0, 4'd9},
    '{1'b1, 1'b0, 5'h11, 16'h00AB, 16'h0000, 1'b0, 4'd2},  // R2 high lane
    '{1'b0, 1'b1, 5'h10, 16'h0000, 16'hAB34, 1'b0, 4'd2},
    '{1'b0, 1'b0, 5'h11, 16'h0000, 16'h00AB, 1'b0, 4'd2},
    '{1'b0, 1'b0, 5'h01, 16'h0000, 16'h0096, 1'b0, 4'd3},  // R3
    '{1'b1, 1'b0, 5'h00, 16'h0011, 16'h0000, 1'b0, 4'd12}, // R12
    '{1'b0, 1'b1, 5'h00, 16'h0000, 16'h9660, 1'b0, 4'd12},
    '{1'b1, 1'b0, 5'h01, 16'h00A5, 16'h0000, 1'b0, 4'd4},  // R4 unlock
    '{1'b1, 1'b1, 5'h0A, 16'hBEEF, 16'h0000, 1'b0, 4'd4},
    '{1'b0, 1'b1, 5'h0A, 16'h0000, 16'hBEEF, 1'b0, 4'd4},
    '{1'b1, 1'b0, 5'h00, 16'h0042, 16'h0000, 1'b0, 4'd4},
    '{1'b0, 1'b1, 5'h00, 16'h0000, 16'h9642, 1'b0, 4'd4},
    '{1'b1, 1'b0, 5'h01, 16'h0033, 16'h0000, 1'b0, 4'd5},  // R5 relock
    '{1'b0, 1'b1, 5'h00, 16'h0000, 16'h9642, 1'b0, 4'd3},
    '{1'b1, 1'b1, 5'h00, 16'hA577, 16'h0000, 1'b0, 4'd6},  // R6
    '{1'b0, 1'b1, 5'h00, 16'h0000, 16'h9677, 1'b0, 4'd6},
    '{1'b1, 1'b0, 5'h0A, 16'h0001, 16'h0000, 1'b0, 4'd2},
    '{1'b0, 1'b1, 5'h0A, 16'h0000, 16'hBE01, 1'b0, 4'd2},
    '{1'b1, 1'b1, 5'h03, 16'hFFFF, 16'h0000, 1'b0, 4'd11}, // R11
    '{1'b0, 1'b1, 5'h02, 16'h0000, 16'h0000, 1'b0, 4'd11},
    '{1'b0, 1'b0, 5'h0B, 16'h0000, 16'h00BE, 1'b0, 4'd2}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              word = 1'b0;
  logic              wr_en = 1'b0;
  logic [15:0]       wdata = '0;
  logic [15:0]       rdata;
  logic              rst_req;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  keyed_regbank #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .addr(addr), .word(word), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic w, input logic [4:0] a, input logic [15:0] d,
                       input logic exp_req, input string tag);
    addr = a; word = w; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    check(tag, {15'd0, rst_req}, {15'd0, exp_req});
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic w, input logic [4:0] a, input logic [15:0] exp,
                       input string tag);
    addr = a; word = w; wr_en = 1'b0;
    @(posedge clk); #1;
    check(tag, rdata, exp);
  endtask

  task automatic idle();
    addr = 5'h1E; word = 1'b0; wr_en = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R1 rst_req after reset", {15'd0, rst_req}, 16'h0000);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_wr)
        do_wr(VEC[i].word, VEC[i].addr, VEC[i].wdata, VEC[i].req,
              $sformatf("R%0d vec %0d write", VEC[i].rq, i));
      else
        do_rd(VEC[i].word, VEC[i].addr, VEC[i].exp,
              $sformatf("R%0d vec %0d read", VEC[i].rq, i));
    end
    // R8: flag write while closed requests reset
    do_wr(1'b0, 5'h01, 16'h0000, 1'b0, "R5 relock before R8");
    do_wr(1'b1, 5'h0A, 16'h1111, 1'b1, "R8 closed flag write");
    idle();
    check("R10 pulse one cycle", {15'd0, rst_req}, 16'h0000);
    do_rd(1'b1, 5'h0A, 16'h0000, "R10 flag reset");
    do_rd(1'b1, 5'h10, 16'h0000, "R10 power-mode reset");
    do_rd(1'b1, 5'h00, 16'h9660, "R10 control reset");
    // R10: bank closed again after the request, open it and let the request close it
    do_wr(1'b0, 5'h01, 16'h00A5, 1'b0, "R4 reopen");
    do_wr(1'b1, 5'h00, 16'h1277, 1'b1, "R7 bad word key");
    idle();
    do_rd(1'b1, 5'h00, 16'h9660, "R7 control unchanged");
    do_wr(1'b0, 5'h0B, 16'h0022, 1'b1, "R10 closed after request");
    idle();
    do_rd(1'b0, 5'h1E, 16'h0000, "R11 unmapped byte read");
    do_wr(1'b0, 5'h1F, 16'h00FF, 1'b0, "R11 unmapped write");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule